// File: doc/BRIEF.md
# Snoop Port Enable Handshake Controller

This block decides which slave ports of a coherent interconnect take part in snoop traffic and in distributed virtual memory (DVM) broadcast traffic. Software writes a small control register for each port. The block turns each control bit into a request level that goes to that port's agent. The agent answers with an acknowledge level. A requested change counts as finished once the acknowledge level matches the request level.

A change does not take effect in the same cycle as the write. While any port's snoop or DVM handshake is unfinished, one global status bit reads as 1. Software polls that bit until it reads 0, and only then treats the change as complete.

The default build has five ports. The two full-coherent ports come first, followed by the three IO-coherent ports. All ports share the same register layout and the same behaviour.

The register space is split into 4 KiB windows, selected by the address bits above bit 12:

- Window 0 holds the global status register at offset 0xC.
- Window p+1 holds the control register of port p at offset 0x0.

A read returns its data one cycle after the read strobe.

Top module: `snpen_ctrl`

## Requirements
- R1: After a synchronous reset, every snoop and DVM request output is 0, every port control register reads 0, and the status register reads 0.
- R2: A write to port p's control register (window p+1, offset 0x0) drives bit 0 of the write data onto `snp_req[p]` and bit 1 onto `dvm_req[p]` from the next cycle on. No other port's request changes.
- R3: Writing 0x3 to a port's control register raises both of that port's requests. Writing 0x0 lowers both.
- R4: A read of a port control register returns the last requested value in bits [1:0], with bit 0 for snoop and bit 1 for DVM. Bits [31:2] of every read are zero, even after a write with those bits set.
- R5: Bit 0 of the status register (window 0, offset 0xC) reads 1 exactly when, for some port, `snp_req` differs from `snp_ack` or `dvm_req` differs from `dvm_ack`. Otherwise it reads 0.
- R6: A new write while a handshake is unfinished updates the request at once. The status stays 1 until the acknowledges match the newest requests. A write that returns a request to the level already acknowledged clears the pending state without any acknowledge change.
- R7: The following have no effect on any request output or register: writes to other offsets in a port window, writes to window 0, and writes to windows beyond the last port. Reads of any such address return 0.
- R8: `bus_rvalid` is 1 in exactly the cycle after `bus_rd` is 1. `bus_rdata` in that cycle reflects the state at the read strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register byte address; bits [15:12] select the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| snp_req | output | 5 | Snoop enable request level, one bit per port |
| snp_ack | input | 5 | Snoop enable acknowledge level from each port agent |
| dvm_req | output | 5 | DVM enable request level, one bit per port |
| dvm_ack | input | 5 | DVM enable acknowledge level from each port agent |

## Verification
The bench drives four kinds of control writes and checks the request outputs and the status bit after each:

- **Single-feature writes to the first port.** These separate the snoop bit from the DVM bit.
- **Both-on and both-off writes to the last port.** These show that window decoding reaches every port and that no neighbouring port is touched.
- **A rewrite while a handshake is unfinished.** Here the acknowledge matches the old request but not the new one. This shows that the status tracks the newest request rather than the first one.
- **Writes to wrong offsets, to the status window and to unmapped windows, plus writes with the upper data bits set.** These confirm that nothing outside the two control bits is ever stored.

// File: rtl/snpen_pkg.sv
// Package: shared constants for the snoop port enable controller.
// Assumes byte addresses with one register window per 2**WIN_SHIFT bytes.
package snpen_pkg;
    // Register offsets inside a window
    localparam int unsigned OFS_CTRL = 32'h0;
    localparam int unsigned OFS_STAT = 32'hC;
    // Bit positions
    localparam int unsigned SNP_BIT  = 0;
    localparam int unsigned DVM_BIT  = 1;
    localparam int unsigned PEND_BIT = 0;
endpackage

// File: rtl/snpen_addr_dec.sv
// Module: address decoder. Window 0 holds the status register; window p+1
// holds port p's control register. Assumes ADDR_W > WIN_SHIFT.
module snpen_addr_dec
    import snpen_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_SHIFT = 12,
    parameter int NPORTS    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORTS-1:0] ctrl_sel,
    output logic              stat_sel
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-1:0] ofs;

    // Split the address into window and offset
    assign win = addr[ADDR_W-1:WIN_SHIFT];
    assign ofs = addr[WIN_SHIFT-1:0];

    // Status register select
    assign stat_sel = (win == '0) && (ofs == WIN_SHIFT'(OFS_STAT));

    // One control-register select per port
    for (genvar p = 0; p < NPORTS; p++) begin : g_sel
        assign ctrl_sel[p] = (win == WIN_W'(p + 1)) && (ofs == WIN_SHIFT'(OFS_CTRL));
    end
endmodule

// File: rtl/snpen_port_ctrl.sv
// Module: one port's control register. Holds the snoop and DVM request levels
// that go straight to the port agent. Assumes wr is already address-qualified.
module snpen_port_ctrl
    import snpen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wbits,
    output logic       snp_req,
    output logic       dvm_req
);
    // Capture the requested feature levels on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_req <= 1'b0;
            dvm_req <= 1'b0;
        end else if (wr) begin
            snp_req <= wbits[SNP_BIT];
            dvm_req <= wbits[DVM_BIT];
        end
    end

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (snp_req == $past(wbits[SNP_BIT]) && dvm_req == $past(wbits[DVM_BIT]))); // R2
    AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(snp_req) && $stable(dvm_req))); // R7
endmodule

// File: rtl/snpen_pend.sv
// Module: global change-pending detector. Flags any port whose acknowledge
// level differs from its request level. Assumes acks are synchronous to clk.
module snpen_pend #(
    parameter int NPORTS = 5
) (
    input  logic [NPORTS-1:0] snp_req,
    input  logic [NPORTS-1:0] snp_ack,
    input  logic [NPORTS-1:0] dvm_req,
    input  logic [NPORTS-1:0] dvm_ack,
    output logic              pending
);
    logic [NPORTS-1:0] port_busy;

    // Per-port mismatch over both features
    for (genvar p = 0; p < NPORTS; p++) begin : g_busy
        assign port_busy[p] = (snp_req[p] ^ snp_ack[p]) | (dvm_req[p] ^ dvm_ack[p]);
    end

    // Reduce to one global flag
    assign pending = |port_busy;
endmodule

// File: rtl/snpen_ctrl.sv
// Module: top of the snoop port enable handshake controller. Decodes the
// register bus, keeps one control register per port, and reports a global
// pending bit. Read data is registered, one cycle after bus_rd.
// Assumes at most one of bus_wr/bus_rd per cycle matters to one address.
module snpen_ctrl
    import snpen_pkg::*;
#(
    parameter int NUM_FULL  = 2,
    parameter int NUM_IO    = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int WIN_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_rvalid,
    output logic [NUM_FULL+NUM_IO-1:0]   snp_req,
    input  logic [NUM_FULL+NUM_IO-1:0]   snp_ack,
    output logic [NUM_FULL+NUM_IO-1:0]   dvm_req,
    input  logic [NUM_FULL+NUM_IO-1:0]   dvm_ack
);
    localparam int NPORTS = NUM_FULL + NUM_IO;

    logic [NPORTS-1:0] ctrl_sel;
    logic              stat_sel;
    logic              pending;
    logic [DATA_W-1:0] rd_next;
    logic              unused_wbits;

    // Only the two control bits of the write data are stored
    assign unused_wbits = ^bus_wdata[DATA_W-1:2];

    // Address decode
    snpen_addr_dec #(
        .ADDR_W   (ADDR_W),
        .WIN_SHIFT(WIN_SHIFT),
        .NPORTS   (NPORTS)
    ) u_dec (
        .addr    (bus_addr),
        .ctrl_sel(ctrl_sel),
        .stat_sel(stat_sel)
    );

    // One control register per port
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        snpen_port_ctrl u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_wr && ctrl_sel[p]),
            .wbits  (bus_wdata[1:0]),
            .snp_req(snp_req[p]),
            .dvm_req(dvm_req[p])
        );
    end

    // Global pending detection
    snpen_pend #(.NPORTS(NPORTS)) u_pend (
        .snp_req(snp_req),
        .snp_ack(snp_ack),
        .dvm_req(dvm_req),
        .dvm_ack(dvm_ack),
        .pending(pending)
    );

    // Read data selection for the addressed register
    always_comb begin
        rd_next = '0;
        if (stat_sel) rd_next[PEND_BIT] = pending;
        for (int p = 0; p < NPORTS; p++) begin
            if (ctrl_sel[p]) begin
                rd_next[SNP_BIT] = snp_req[p];
                rd_next[DVM_BIT] = dvm_req[p];
            end
        end
    end

    // Register the read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_next : '0;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R8
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[DATA_W-1:2] == '0)); // R4
    AST_STAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && stat_sel && snp_req == snp_ack && dvm_req == dvm_ack) |=> (bus_rdata == '0)); // R5
    AST_STAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && stat_sel && (snp_req != snp_ack || dvm_req != dvm_ack)) |=> bus_rdata[0]); // R6
endmodule

// File: tb/snpen_ctrl_tb.sv
// Scoreboard bench: the read driver pushes expected values, a monitor pops
// and compares them when read data comes back.
module snpen_ctrl_tb;
    localparam int NP = 5;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] snp_req, dvm_req;
    logic [NP-1:0] snp_ack = '0;
    logic [NP-1:0] dvm_ack = '0;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    // Bench model of the requested levels
    logic [NP-1:0] m_snp = '0;
    logic [NP-1:0] m_dvm = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    snpen_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .snp_req(snp_req), .snp_ack(snp_ack),
        .dvm_req(dvm_req), .dvm_ack(dvm_ack)
    );

    function automatic logic [31:0] model_read(input logic [15:0] a);
        logic [3:0]  w;
        logic [11:0] o;
        w = a[15:12];
        o = a[11:0];
        if (w == 0 && o == 12'hC) return {31'd0, (|(m_snp ^ snp_ack)) | (|(m_dvm ^ dvm_ack))};
        if (w >= 1 && w <= NP && o == 12'h0) return {30'd0, m_dvm[w-1], m_snp[w-1]};
        return 32'd0;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[15:12] >= 1 && a[15:12] <= NP && a[11:0] == 12'h0) begin
            m_snp[a[15:12]-1] = d[0];
            m_dvm[a[15:12]-1] = d[1];
        end
    endtask

    // Driver: issue a read and push its expected value
    task automatic rd(input logic [15:0] a, input string tag);
        @(negedge clk);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_ack(input logic [NP-1:0] s, input logic [NP-1:0] d);
        @(negedge clk);
        snp_ack = s; dvm_ack = d;
    endtask

    task automatic chk_req(input string tag);
        @(negedge clk);
        checks++;
        if (snp_req !== m_snp || dvm_req !== m_dvm) begin
            errors++;
            $display("FAIL %s: snp_req=%b dvm_req=%b expected snp=%b dvm=%b",
                     tag, snp_req, dvm_req, m_snp, m_dvm);
        end
    endtask

    // Monitor: compare returned read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected rvalid, rdata=%h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_req("R1 reset requests");
        rd(16'h000C, "R1 reset status");
        for (int p = 0; p < NP; p++) rd(16'((p + 1) << 12), "R1 reset ctrl");

        wr(16'h1000, 32'h1);
        chk_req("R2 snoop bit port0");
        rd(16'h000C, "R5 pending after snoop write");
        rd(16'h1000, "R4 readback port0");
        set_ack(5'b00001, 5'b00000);
        rd(16'h000C, "R5 idle after snoop ack");
        wr(16'h1000, 32'h2);
        chk_req("R2 dvm bit port0");
        set_ack(5'b00000, 5'b00001);
        rd(16'h000C, "R5 idle after dvm ack");

        wr(16'h5000, 32'h3);
        chk_req("R3 enable both port4");
        rd(16'h000C, "R5 pending port4");
        set_ack(5'b10000, 5'b10001);
        rd(16'h000C, "R5 idle port4");
        wr(16'h5000, 32'h0);
        chk_req("R3 disable both port4");
        rd(16'h5000, "R3 readback port4 zero");
        set_ack(5'b00000, 5'b00001);
        rd(16'h000C, "R5 idle after disable");

        wr(16'h2000, 32'h2);
        rd(16'h000C, "R6 pending port1");
        wr(16'h2000, 32'h0);
        chk_req("R6 newest request port1");
        rd(16'h000C, "R6 cleared by rewrite");
        wr(16'h2000, 32'h2);
        set_ack(5'b00000, 5'b00011);
        wr(16'h2000, 32'h1);
        rd(16'h000C, "R6 pending on newest request");
        set_ack(5'b00010, 5'b00001);
        rd(16'h000C, "R6 idle after newest ack");

        wr(16'h4000, 32'hFFFF_FFFC);
        rd(16'h4000, "R4 upper bits dropped");
        wr(16'h4000, 32'hFFFF_FFFF);
        rd(16'h4000, "R4 readback masked");
        chk_req("R2 port3 only");

        wr(16'h1004, 32'h0);
        wr(16'h6000, 32'h3);
        wr(16'h000C, 32'h0);
        wr(16'h0000, 32'h3);
        chk_req("R7 ignored writes");
        rd(16'h7000, "R7 unmapped read");
        rd(16'h1008, "R7 bad offset read");
        rd(16'h1000, "R7 port0 kept");

        for (int p = 0; p < NP; p++) begin
            wr(16'((p + 1) << 12), 32'(p % 4));
            chk_req("R8 window map");
            rd(16'((p + 1) << 12), "R8 window readback");
        end
        set_ack(m_snp, m_dvm);
        rd(16'h000C, "R5 all acknowledged");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d reads unanswered, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule